// File: doc/BRIEF.md
# Three-Wire Serial Memory Slave

This block is the device end of a three-wire serial memory link. A host selects it with a chip-select line, moves a serial clock and presents bits on a data input. The block waits for a start bit, then takes a two-bit opcode and a nine-bit address. Write-type commands also take an eight-bit data word. The block then reads, writes or erases bytes of an internal 512-byte array. It also has commands to set and clear a write-enable latch. The serial inputs are sampled by the chip's own clock, and each serial-clock rise is found by edge detection.

Every write or erase starts a programming interval, modelled by a countdown of the system clock. During that interval the block accepts no new command. If the host drops chip select and raises it again while the interval runs, the data output reports busy (low) and then ready (high). Outside a read and this status report, the output is not driven. It is presented as a data bit plus a separate drive enable.

Top module: `mw_eeprom_slave`

## Requirements
- R1: While chip select is low, dout_en is low from the next system clock on, and a partly received command is discarded.
- R2: While selected and idle, serial clock rises with din = 0 leave the block waiting; the first rise with din = 1 is the start bit.
- R3: After the start bit come the opcode (MSB first) and the address A8..A0 (MSB first). Opcode 10 is a read. dout_en stays low through the 12th rise. Rises 13 to 20 each drive one stored bit on dout, D7 first, with dout_en high.
- R4: Opcode 01 followed by 8 data bits (MSB first, 20 rises in all) stores the byte at the address when writes are enabled.
- R5: Opcode 11 (12 rises) sets the addressed byte to 0xFF when writes are enabled.
- R6: Opcode 00 with A8A7 = 11 enables writes, and A8A7 = 00 disables them. Writes are disabled after reset. While disabled, commands that write or erase change no byte and start no busy interval.
- R7: Opcode 00 with A8A7 = 01 plus 8 data bits writes that byte to every address. With A8A7 = 10 it sets every byte to 0xFF (12 rises). In both, A6..A0 are ignored.
- R8: An accepted write or erase keeps the block busy for PROG_CYCLES system clocks, starting on the clock after its last rise. Start bits sent while busy are ignored.
- R9: When chip select rises while busy, dout_en goes high. dout is 0 while busy and 1 once ready. If chip select stays low for the whole interval, dout_en stays low.
- R10: Once a command has received its full count of rises, further rises and din values are ignored until chip select goes low.
- R11: A programming interval that has begun runs to its end even if chip select drops during it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs | input | 1 | Chip select, high selects |
| sclk | input | 1 | Serial clock, sampled by clk |
| din | input | 1 | Serial data in |
| dout | output | 1 | Serial data out value |
| dout_en | output | 1 | Drive enable for dout; low means high impedance |

## Verification
A serial-clock rise takes effect on the system clock edge that first sees sclk high. Read bits and the write-enable latch change on that edge. The bench drives each bit over two falling clock edges and samples dout on the falling edge that follows, so each read bit is checked right after its own rise. Memory updates and the busy countdown begin one edge after the last rise. The status checks therefore count falling edges from that point and expect dout low through PROG_CYCLES edges and high on the one after. A chip-select change acts on dout_en one edge later, and the checks sample a full clock after each change.

// File: rtl/mw_pkg.sv
// Shared types for the serial memory slave.
// Assumes nothing beyond the opcode values used on the wire.
package mw_pkg;
    typedef enum logic [1:0] {
        OP_EXT   = 2'b00,
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10,
        OP_ERASE = 2'b11
    } op_t;

    // Sub-codes carried in the top two address bits of OP_EXT.
    localparam logic [1:0] EXT_WDIS = 2'b00;
    localparam logic [1:0] EXT_WALL = 2'b01;
    localparam logic [1:0] EXT_EALL = 2'b10;
    localparam logic [1:0] EXT_WEN  = 2'b11;

    typedef enum logic [2:0] {
        F_IDLE, F_HDR, F_DATA, F_READ, F_DONE
    } fstate_t;
endpackage

// File: rtl/mw_edge.sv
// Edge finder for the sampled serial clock and chip select.
// Assumes sclk and cs are already synchronous to clk.
module mw_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cs,
    output logic sclk_rise,
    output logic cs_rise
);
    logic sclk_q, cs_q;

    // Keep last-cycle copies of the serial clock and chip select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            cs_q   <= 1'b0;
        end else begin
            sclk_q <= sclk;
            cs_q   <= cs;
        end
    end

    assign sclk_rise = sclk & ~sclk_q;
    assign cs_rise   = cs & ~cs_q;
endmodule

// File: rtl/mw_prog_timer.sv
// Countdown that models the self-timed programming interval.
// Assumes start is never raised while busy.
module mw_prog_timer #(
    parameter int PROG_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(PROG_CYCLES + 1);
    logic [CW-1:0] cnt;

    // Load on start, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (start)
            cnt <= CW'(PROG_CYCLES);
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);

    a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);
    a_r8_busy_follows: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);
endmodule

// File: rtl/mw_frame.sv
// Serial command receiver: finds the start bit, gathers opcode, address
// and data, shifts out read data and issues a one-cycle command pulse.
// Assumes rd_byte is the array content at rd_addr in the same cycle.
module mw_frame
    import mw_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              rise,
    input  logic              din,
    input  logic              busy,
    input  logic [DATA_W-1:0] rd_byte,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              active,
    output logic              cmd_go,
    output op_t               cmd_op,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [DATA_W-1:0] cmd_data,
    output logic              rd_bit,
    output logic              rd_oe
);
    localparam int HDR_BITS = 2 + ADDR_W;
    localparam int SREG_W   = HDR_BITS + DATA_W;
    localparam int BW       = $clog2(HDR_BITS + 1);
    localparam int OW       = $clog2(DATA_W + 1);

    fstate_t           state;
    logic [SREG_W-1:0] sreg;
    logic [SREG_W-1:0] nxt;
    logic [BW-1:0]     bcnt;
    logic [OW-1:0]     ocnt;
    logic [DATA_W-1:0] obuf;
    op_t               hop;
    logic [1:0]        hext;

    assign nxt     = {sreg[SREG_W-2:0], din};
    assign rd_addr = nxt[ADDR_W-1:0];
    assign hop     = op_t'(nxt[HDR_BITS-1 -: 2]);
    assign hext    = nxt[ADDR_W-1 -: 2];
    assign active  = (state != F_IDLE);

    // Frame state machine, shifter and read output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= F_IDLE;
            sreg   <= '0;
            bcnt   <= '0;
            ocnt   <= '0;
            obuf   <= '0;
            rd_bit <= 1'b0;
            rd_oe  <= 1'b0;
            cmd_go <= 1'b0;
            cmd_op <= OP_EXT;
            cmd_addr <= '0;
            cmd_data <= '0;
        end else begin
            cmd_go <= 1'b0;
            if (!cs) begin
                state <= F_IDLE;
                bcnt  <= '0;
                rd_oe <= 1'b0;
            end else if (rise) begin
                case (state)
                    F_IDLE: if (din && !busy) begin
                        state <= F_HDR;
                        bcnt  <= '0;
                    end
                    F_HDR: begin
                        sreg <= nxt;
                        bcnt <= bcnt + 1'b1;
                        if (bcnt == BW'(HDR_BITS - 1)) begin
                            bcnt <= '0;
                            if (hop == OP_READ) begin
                                state <= F_READ;
                                obuf  <= rd_byte;
                                ocnt  <= '0;
                            end else if (hop == OP_WRITE ||
                                         (hop == OP_EXT && hext == EXT_WALL)) begin
                                state <= F_DATA;
                            end else begin
                                state    <= F_DONE;
                                cmd_go   <= 1'b1;
                                cmd_op   <= hop;
                                cmd_addr <= nxt[ADDR_W-1:0];
                            end
                        end
                    end
                    F_DATA: begin
                        sreg <= nxt;
                        bcnt <= bcnt + 1'b1;
                        if (bcnt == BW'(DATA_W - 1)) begin
                            state    <= F_DONE;
                            cmd_go   <= 1'b1;
                            cmd_op   <= op_t'(nxt[SREG_W-1 -: 2]);
                            cmd_addr <= nxt[DATA_W +: ADDR_W];
                            cmd_data <= nxt[DATA_W-1:0];
                        end
                    end
                    F_READ: begin
                        if (ocnt < OW'(DATA_W)) begin
                            rd_bit <= obuf[DATA_W-1];
                            obuf   <= {obuf[DATA_W-2:0], 1'b0};
                            ocnt   <= ocnt + 1'b1;
                            rd_oe  <= 1'b1;
                        end else begin
                            state <= F_DONE;
                            rd_oe <= 1'b0;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    a_r2_wait_start: assert property (@(posedge clk) disable iff (!rst_n)
        (state == F_IDLE && !(rise && din)) |=> state == F_IDLE);
    a_r8_ignore_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (state == F_IDLE && busy) |=> state == F_IDLE);
    a_r10_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state == F_DONE && cs) |=> state == F_DONE);
    a_r1_drop_frame: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |=> (state == F_IDLE && !rd_oe));
endmodule

// File: rtl/mw_eeprom_slave.sv
// Top: serial memory slave with a byte array, write-enable latch,
// programming timer and ready/busy status on the data output.
// Assumes cs, sclk and din change synchronously to clk.
module mw_eeprom_slave
    import mw_pkg::*;
#(
    parameter int ADDR_W      = 9,
    parameter int DATA_W      = 8,
    parameter int PROG_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic sclk,
    input  logic din,
    output logic dout,
    output logic dout_en
);
    localparam int DEPTH = 1 << ADDR_W;

    logic              sclk_rise, cs_rise, busy, active;
    logic              cmd_go, rd_bit, rd_oe, prog_start, wen_q, stat_q;
    op_t               cmd_op;
    logic [ADDR_W-1:0] rd_addr, cmd_addr;
    logic [DATA_W-1:0] cmd_data, rd_byte;
    logic [DATA_W-1:0] mem [DEPTH];

    mw_edge u_edge (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs(cs),
        .sclk_rise(sclk_rise), .cs_rise(cs_rise)
    );

    mw_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
        .clk(clk), .rst_n(rst_n), .cs(cs), .rise(sclk_rise), .din(din),
        .busy(busy), .rd_byte(rd_byte), .rd_addr(rd_addr), .active(active),
        .cmd_go(cmd_go), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
        .cmd_data(cmd_data), .rd_bit(rd_bit), .rd_oe(rd_oe)
    );

    mw_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(prog_start), .busy(busy)
    );

    assign rd_byte = mem[rd_addr];

    // A command alters the array only when the enable latch is set.
    always_comb begin
        prog_start = 1'b0;
        if (cmd_go && wen_q) begin
            case (cmd_op)
                OP_WRITE, OP_ERASE: prog_start = 1'b1;
                OP_EXT: prog_start = (cmd_addr[ADDR_W-1 -: 2] == EXT_WALL) ||
                                     (cmd_addr[ADDR_W-1 -: 2] == EXT_EALL);
                default: prog_start = 1'b0;
            endcase
        end
    end

    // Write-enable latch, set and cleared by the extended opcodes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wen_q <= 1'b0;
        else if (cmd_go && cmd_op == OP_EXT) begin
            if (cmd_addr[ADDR_W-1 -: 2] == EXT_WEN)
                wen_q <= 1'b1;
            else if (cmd_addr[ADDR_W-1 -: 2] == EXT_WDIS)
                wen_q <= 1'b0;
        end
    end

    // Byte array update for single and whole-array programming.
    always_ff @(posedge clk) begin
        if (prog_start) begin
            if (cmd_op == OP_WRITE)
                mem[cmd_addr] <= cmd_data;
            else if (cmd_op == OP_ERASE)
                mem[cmd_addr] <= '1;
            else begin
                for (int i = 0; i < DEPTH; i++)
                    mem[i] <= (cmd_addr[ADDR_W-1 -: 2] == EXT_WALL) ? cmd_data : '1;
            end
        end
    end

    // Status mode: armed by a chip-select rise while busy, left on deselect or start.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stat_q <= 1'b0;
        else if (!cs || active)
            stat_q <= 1'b0;
        else if (cs_rise && busy)
            stat_q <= 1'b1;
    end

    assign dout_en = stat_q | rd_oe;
    assign dout    = stat_q ? ~busy : rd_bit;

    a_r1_release: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |=> !dout_en);
    a_r6_protect: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_go && !wen_q) |=> !busy);
    a_r9_status_arm: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rise && busy) |=> (dout_en && !dout));
    a_r9_single_driver: assert property (@(posedge clk) disable iff (!rst_n)
        !(stat_q && rd_oe));
endmodule

// File: tb/mw_eeprom_slave_test.sv
module mw_eeprom_slave_test;
    localparam int PROG = 64;

    logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sclk = 1'b0, din = 1'b0;
    logic dout, dout_en;
    int checks = 0, fails = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    mw_eeprom_slave #(.PROG_CYCLES(PROG)) uut (
        .clk(clk), .rst_n(rst_n), .cs(cs), .sclk(sclk), .din(din),
        .dout(dout), .dout_en(dout_en)
    );

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_bit(logic b);
        @(negedge clk); din = b; sclk = 1'b1;
        @(negedge clk); sclk = 1'b0;
    endtask

    task automatic send(logic [19:0] v, int n);
        for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
    endtask

    task automatic sel;
        @(negedge clk); cs = 1'b1;
        @(negedge clk);
    endtask

    task automatic desel;
        @(negedge clk); cs = 1'b0; din = 1'b0; sclk = 1'b0;
        @(negedge clk);
    endtask

    task automatic cmd(logic [19:0] v, int n);
        sel(); send(v, n); desel();
    endtask

    task automatic settle;
        desel();
        repeat (PROG + 4) @(negedge clk);
    endtask

    task automatic rd(logic [8:0] a, string req, logic [7:0] exp);
        logic [7:0] got;
        sel();
        send({8'h0, 1'b1, 2'b10, a}, 12);
        chk({req, "/R3 no drive before data"}, 16'(dout_en), 16'h0);
        for (int i = 7; i >= 0; i--) begin
            send_bit(1'b0);
            got[i] = dout;
            chk({req, "/R3 drive during data"}, 16'(dout_en), 16'h1);
        end
        chk(req, 16'(got), 16'(exp));
        send_bit(1'b1);
        chk("R10 released after read", 16'(dout_en), 16'h0);
        desel();
    endtask

    function automatic logic [19:0] f_wr(logic [8:0] a, logic [7:0] d);
        return {1'b1, 2'b01, a, d};
    endfunction
    function automatic logic [19:0] f_er(logic [8:0] a);
        return {8'h0, 1'b1, 2'b11, a};
    endfunction
    localparam logic [19:0] F_WEN  = {8'h0, 1'b1, 2'b00, 9'h180};
    localparam logic [19:0] F_WDIS = {8'h0, 1'b1, 2'b00, 9'h000};
    localparam logic [19:0] F_EALL = {8'h0, 1'b1, 2'b00, 9'h13F};
    function automatic logic [19:0] f_wall(logic [7:0] d);
        return {1'b1, 2'b00, 9'h0AA, d};
    endfunction

    task automatic t_reset;
        chk("R1 reset output released", 16'(dout_en), 16'h0);
        chk("R6 reset write disabled", 16'(uut.u_timer.busy), 16'h0);
    endtask

    task automatic t_protect;
        cmd(F_WEN, 12); cmd(F_EALL, 12); settle();
        cmd(F_WDIS, 12);
        cmd(f_wr(9'h003, 8'h5A), 20);
        sel();
        chk("R6 no busy when disabled", 16'(dout_en), 16'h0);
        desel();
        rd(9'h003, "R6 write ignored", 8'hFF);
    endtask

    task automatic t_preamble;
        cmd(F_WEN, 12);
        cmd(f_wr(9'h07E, 8'hA6), 20); settle();
        sel();
        send(20'h0, 10);
        chk("R2 idle zeros no drive", 16'(dout_en), 16'h0);
        send({8'h0, 1'b1, 2'b10, 9'h07E}, 12);
        for (int i = 7; i >= 0; i--) begin
            send_bit(1'b0);
            chk("R2 read after zeros", 16'(dout), 16'((8'hA6 >> i) & 1));
        end
        desel();
    endtask

    task automatic t_write_erase;
        cmd(f_wr(9'h1A5, 8'hC3), 20); settle();
        rd(9'h1A5, "R4 write stored", 8'hC3);
        rd(9'h0A5, "R4 neighbour untouched", 8'hFF);
        sel(); send(f_er(9'h1A5), 12); send(20'h0, 8); desel(); settle();
        rd(9'h1A5, "R5 R10 erase, extra bits ignored", 8'hFF);
    endtask

    task automatic t_all;
        cmd(f_wall(8'h3C), 20); settle();
        rd(9'h000, "R7 write-all low", 8'h3C);
        rd(9'h1FF, "R7 write-all high", 8'h3C);
        cmd(F_EALL, 12); settle();
        rd(9'h123, "R7 erase-all", 8'hFF);
    endtask

    task automatic t_status_timing;
        sel();
        send(f_wr(9'h010, 8'h81), 20);
        cs = 1'b0;
        @(negedge clk); cs = 1'b1;
        @(negedge clk);
        chk("R9 status busy", 16'({dout_en, dout}), 16'h2);
        repeat (PROG - 2) @(negedge clk);
        chk("R8 busy through last cycle", 16'({dout_en, dout}), 16'h2);
        @(negedge clk);
        chk("R8 R9 ready after interval", 16'({dout_en, dout}), 16'h3);
        desel();
        rd(9'h010, "R4 timed write stored", 8'h81);
    endtask

    task automatic t_hiz_busy;
        cmd(f_wr(9'h011, 8'h22), 20);
        repeat (PROG / 2) begin
            @(negedge clk);
            if (dout_en !== 1'b0) chk("R9 undriven with cs low", 16'(dout_en), 16'h0);
        end
        chk("R9 undriven with cs low", 16'(dout_en), 16'h0);
        sel();
        chk("R11 still busy after deselect", 16'({dout_en, dout}), 16'h2);
        desel(); settle();
    endtask

    task automatic t_ignore_busy;
        cmd(f_wr(9'h012, 8'h44), 20);
        sel();
        send({8'h0, 1'b1, 2'b10, 9'h012}, 12);
        send(20'h0, 3);
        chk("R8 read ignored while busy", 16'({dout_en, dout}), 16'h2);
        desel(); settle();
        rd(9'h012, "R11 write completed", 8'h44);
    endtask

    task automatic t_abort;
        sel();
        send({8'h0, 1'b1, 2'b01, 9'h012}, 8);
        desel();
        sel();
        send({8'h0, 1'b1, 2'b10, 9'h012}, 12);
        send_bit(1'b0);
        chk("R1 read drives after aborted frame", 16'(dout_en), 16'h1);
        @(negedge clk); cs = 1'b0;
        @(negedge clk);
        chk("R1 deselect releases mid-read", 16'(dout_en), 16'h0);
        desel();
        rd(9'h012, "R1 aborted write had no effect", 8'h44);
    endtask

    task automatic t_disable;
        cmd(F_WDIS, 12);
        cmd(f_er(9'h012), 12); settle();
        rd(9'h012, "R6 erase ignored when disabled", 8'h44);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_protect();
        t_preamble();
        t_write_erase();
        t_all();
        t_status_timing();
        t_hiz_busy();
        t_ignore_busy();
        t_abort();
        t_disable();
        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule